// File: doc/BRIEF.md
# Sponge Hash Command Sequencer

This block is the control sequencer that steps a sponge-construction hash engine through its phases. Software issues four commands: begin a message (start), push data (process), request an extra permutation (run) and finish (done). The sequencer checks each command against the phase it is in. It also watches two events from neighbouring logic: the padding unit reporting that the whole message has been absorbed, and the round logic reporting that a permutation has finished. The permutation datapath, the padder and the state storage lie outside the block. Only their handshakes arrive here.

The phases are Idle, Absorb, Squeeze, ManualRun, Flush and a sticky Halt state. Each phase is stored in a sparse six-bit code. The done, absorbed and escalation inputs are 4-bit multi-bit booleans: 4'b0110 means true and 4'b1001 means false. A strict test accepts only 4'b0110. A loose test treats every pattern except 4'b1001 as true.

The block produces four results. The first is the message-mux select, which releases the message path only while absorbing. The second is the permutation run request. The third is a one-cycle command-sequence error. The fourth is a fatal flag, formed from its own state fault and the state faults of its neighbours. A combined counter-fault output is also provided.

Top module: `sponge_seq_ctrl`

## Requirements
- R1: While reset is asserted, and after it is released, the block is in Idle. In Idle, msg_pass_o, fatal_o, seq_err_o and perm_run_o are all 0 when no command is given.
- R2: In Idle, start_i moves the block to Absorb on the next clock edge. msg_pass_o is 1 from the following cycle onward.
- R3: Absorb moves to Squeeze only when absorbed_i equals 4'b0110 exactly. Any other pattern, 4'b0111 included, keeps the block in Absorb.
- R4: In Squeeze, run_i moves the block to ManualRun. It takes priority over done_i. Without run_i, done_i equal to 4'b0110 moves the block to Flush. A loosely-true value such as 4'b0111 does not.
- R5: ManualRun ignores done_i. It returns to Squeeze on the edge where perm_done_i is 1.
- R6: Flush lasts exactly one cycle and then enters Idle.
- R7: When escalate_i is any pattern other than 4'b1001, the block enters Halt on the next edge from any state. Halt holds fatal_o at 1 and is left only by reset. Commands given in Halt are ignored and raise no sequence error.
- R8: seq_err_o is 1 in the same cycle as an illegal command, and the command does not change the state. The illegal commands are:
  - in Idle: process_i, run_i, or a loosely-true done_i;
  - in Absorb: start_i, run_i, a loosely-true done_i, or process_i while a message is being processed;
  - in Squeeze and ManualRun: start_i or process_i;
  - in Flush: any command.
- R9: A processing flag is set on the edge after process_i. It is cleared on the edge after absorbed_i equals 4'b0110, unless process_i is present in that cycle.
- R10: perm_run_o is the OR of pad_run_i and a software request. The software request is run_i seen while in Squeeze. perm_run_o follows both in the same cycle.
- R11: fatal_o is the OR of pad_state_err_i, round_state_err_i and the block's own state fault, which is Halt or an illegal code. cnt_err_o is the OR of round_cnt_err_i and msg_cnt_err_i. Both follow their inputs in the same cycle.
- R12: msg_pass_o is 1 only while the state is Absorb. Any select code other than the two legal ones decodes to the closed path.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| start_i | input | 1 | Begin-message command |
| process_i | input | 1 | Push-data command |
| run_i | input | 1 | Manual permutation command |
| done_i | input | 4 | Finish command, multi-bit boolean |
| absorbed_i | input | 4 | Message-fully-absorbed indication from the padder, multi-bit boolean |
| perm_done_i | input | 1 | Permutation-complete pulse from the round logic |
| escalate_i | input | 4 | Escalation request, multi-bit boolean |
| pad_run_i | input | 1 | Permutation request from the padder |
| pad_state_err_i | input | 1 | Padder state fault |
| round_state_err_i | input | 1 | Round controller state fault |
| round_cnt_err_i | input | 1 | Round counter fault |
| msg_cnt_err_i | input | 1 | Message counter fault |
| msg_pass_o | output | 1 | Message mux select: 1 means released, 0 means guarded |
| perm_run_o | output | 1 | Permutation run request |
| seq_err_o | output | 1 | Command-sequence error pulse |
| fatal_o | output | 1 | Fatal state fault |
| cnt_err_o | output | 1 | Counter fault |

## Verification
The block produces results at two latencies.

- Same cycle: seq_err_o, perm_run_o, cnt_err_o and the input-fed part of fatal_o are combinational. They are due in the cycle the stimulus is applied.
- Next cycle: a state change, and therefore msg_pass_o and the Halt part of fatal_o, appears only after the next rising edge.

The bench applies each stimulus after a falling edge and samples one time unit later, still before the rising edge. A same-cycle result is therefore compared against the vector that caused it. A state-derived result is compared against the vector of the following row, since that row is sampled after the edge that stored the transition.

// File: rtl/sponge_seq_pkg.sv
package sponge_seq_pkg;

    // Multi-bit boolean encoding
    localparam int MbW = 4;
    localparam logic [MbW-1:0] MB_TRUE  = 4'b0110;
    localparam logic [MbW-1:0] MB_FALSE = 4'b1001;

    // Sparse phase encoding, pairwise Hamming distance of at least three
    localparam int StW = 6;
    typedef enum logic [StW-1:0] {
        ST_IDLE    = 6'b000111,
        ST_ABSORB  = 6'b011010,
        ST_SQUEEZE = 6'b101100,
        ST_MANRUN  = 6'b110001,
        ST_FLUSH   = 6'b111111,
        ST_HALT    = 6'b100010
    } seq_state_e;

    // Message mux select, two legal codes
    localparam int SelW = 4;
    typedef enum logic [SelW-1:0] {
        SEL_GUARD   = 4'b1100,
        SEL_RELEASE = 4'b0011
    } sel_e;

    function automatic logic mb_strict(input logic [MbW-1:0] v);
        return v == MB_TRUE;
    endfunction

    function automatic logic mb_loose(input logic [MbW-1:0] v);
        return v != MB_FALSE;
    endfunction

endpackage

// File: rtl/sponge_seq_busy.sv
// Processing flag: set by a push command, cleared once the padder reports absorption.
module sponge_seq_busy (
    input  logic clk_i,
    input  logic rst_ni,
    input  logic process_i,
    input  logic absorbed_i,
    output logic busy_o
);
    typedef struct packed {
        logic busy;
    } busy_regs_t;

    busy_regs_t r_d, r_q;

    always_comb begin
        r_d = r_q;
        if (process_i) begin
            r_d.busy = 1'b1;
        end else if (absorbed_i) begin
            r_d.busy = 1'b0;
        end
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) r_q <= '0;
        else         r_q <= r_d;
    end

    assign busy_o = r_q.busy;

    // R9
    assert_busy_set_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
        process_i |=> busy_o);
    // R9
    assert_busy_clear_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (!process_i && absorbed_i) |=> !busy_o);

endmodule

// File: rtl/sponge_seq_cmdchk.sv
// Per-phase legality check of software commands, and the software permutation request.
module sponge_seq_cmdchk
    import sponge_seq_pkg::*;
(
    input  seq_state_e state_i,
    input  logic       start_i,
    input  logic       process_i,
    input  logic       run_i,
    input  logic       done_loose_i,
    input  logic       busy_i,
    output logic       seq_err_o,
    output logic       sw_run_o
);
    always_comb begin
        seq_err_o = 1'b0;
        case (state_i)
            ST_IDLE:    seq_err_o = process_i | run_i | done_loose_i;
            ST_ABSORB:  seq_err_o = start_i | run_i | done_loose_i | (process_i & busy_i);
            ST_SQUEEZE: seq_err_o = start_i | process_i;
            ST_MANRUN:  seq_err_o = start_i | process_i;
            ST_FLUSH:   seq_err_o = start_i | process_i | run_i | done_loose_i;
            default:    seq_err_o = 1'b0;
        endcase
    end

    // A manual permutation is requested only from the squeeze phase
    assign sw_run_o = (state_i == ST_SQUEEZE) & run_i;

endmodule

// File: rtl/sponge_seq_fsm.sv
// Phase register with sparse encoding, escalation into a sticky halt, and the mux select register.
module sponge_seq_fsm
    import sponge_seq_pkg::*;
(
    input  logic       clk_i,
    input  logic       rst_ni,
    input  logic       start_i,
    input  logic       run_i,
    input  logic       done_strict_i,
    input  logic       absorbed_i,
    input  logic       perm_done_i,
    input  logic       escalate_i,
    output seq_state_e state_o,
    output sel_e       sel_o,
    output logic       state_err_o
);
    typedef struct packed {
        seq_state_e st;
        sel_e       sel;
    } fsm_regs_t;

    fsm_regs_t r_d, r_q;

    always_comb begin
        r_d         = r_q;
        state_err_o = 1'b0;
        case (r_q.st)
            ST_IDLE: begin
                if (start_i) r_d.st = ST_ABSORB;
            end
            ST_ABSORB: begin
                if (absorbed_i) r_d.st = ST_SQUEEZE;
            end
            ST_SQUEEZE: begin
                if (run_i)              r_d.st = ST_MANRUN;
                else if (done_strict_i) r_d.st = ST_FLUSH;
            end
            ST_MANRUN: begin
                if (perm_done_i) r_d.st = ST_SQUEEZE;
            end
            ST_FLUSH: begin
                r_d.st = ST_IDLE;
            end
            ST_HALT: begin
                state_err_o = 1'b1;
            end
            default: begin
                // Illegal code: treat as a fault and lock up
                r_d.st      = ST_HALT;
                state_err_o = 1'b1;
            end
        endcase

        if (escalate_i) r_d.st = ST_HALT;

        r_d.sel = (r_d.st == ST_ABSORB) ? SEL_RELEASE : SEL_GUARD;
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) begin
            r_q.st  <= ST_IDLE;
            r_q.sel <= SEL_GUARD;
        end else begin
            r_q <= r_d;
        end
    end

    assign state_o = r_q.st;
    assign sel_o   = r_q.sel;

    // R7
    assert_halt_sticky_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (r_q.st == ST_HALT) |=> (r_q.st == ST_HALT));
    // R7
    assert_escalate_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
        escalate_i |=> (r_q.st == ST_HALT));
    // R6
    assert_flush_idle_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (r_q.st == ST_FLUSH && !escalate_i) |=> (r_q.st == ST_IDLE));
    // R3
    assert_absorb_hold_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (r_q.st == ST_ABSORB && !absorbed_i && !escalate_i) |=> (r_q.st == ST_ABSORB));
    // R5
    assert_manrun_hold_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (r_q.st == ST_MANRUN && !perm_done_i && !escalate_i) |=> (r_q.st == ST_MANRUN));

endmodule

// File: rtl/sponge_seq_ctrl.sv
// Top of the sponge command sequencer.
module sponge_seq_ctrl
    import sponge_seq_pkg::*;
(
    input  logic           clk_i,
    input  logic           rst_ni,
    input  logic           start_i,
    input  logic           process_i,
    input  logic           run_i,
    input  logic [MbW-1:0] done_i,
    input  logic [MbW-1:0] absorbed_i,
    input  logic           perm_done_i,
    input  logic [MbW-1:0] escalate_i,
    input  logic           pad_run_i,
    input  logic           pad_state_err_i,
    input  logic           round_state_err_i,
    input  logic           round_cnt_err_i,
    input  logic           msg_cnt_err_i,
    output logic           msg_pass_o,
    output logic           perm_run_o,
    output logic           seq_err_o,
    output logic           fatal_o,
    output logic           cnt_err_o
);
    // Multi-bit decodes: strict for transitions, loose for checks and escalation
    logic done_strict, done_loose, absorbed_strict, escalate_loose;
    assign done_strict     = mb_strict(done_i);
    assign done_loose      = mb_loose(done_i);
    assign absorbed_strict = mb_strict(absorbed_i);
    assign escalate_loose  = mb_loose(escalate_i);

    seq_state_e state_q;
    sel_e       sel_q;
    logic       fsm_err;
    logic       busy;
    logic       sw_run;

    sponge_seq_fsm u_fsm (
        .clk_i         (clk_i),
        .rst_ni        (rst_ni),
        .start_i       (start_i),
        .run_i         (run_i),
        .done_strict_i (done_strict),
        .absorbed_i    (absorbed_strict),
        .perm_done_i   (perm_done_i),
        .escalate_i    (escalate_loose),
        .state_o       (state_q),
        .sel_o         (sel_q),
        .state_err_o   (fsm_err)
    );

    sponge_seq_busy u_busy (
        .clk_i      (clk_i),
        .rst_ni     (rst_ni),
        .process_i  (process_i),
        .absorbed_i (absorbed_strict),
        .busy_o     (busy)
    );

    sponge_seq_cmdchk u_chk (
        .state_i      (state_q),
        .start_i      (start_i),
        .process_i    (process_i),
        .run_i        (run_i),
        .done_loose_i (done_loose),
        .busy_i       (busy),
        .seq_err_o    (seq_err_o),
        .sw_run_o     (sw_run)
    );

    // Select decode: only the release code opens the message path
    always_comb begin
        case (sel_q)
            SEL_RELEASE: msg_pass_o = 1'b1;
            SEL_GUARD:   msg_pass_o = 1'b0;
            default:     msg_pass_o = 1'b0;
        endcase
    end

    assign perm_run_o = pad_run_i | sw_run;
    assign fatal_o    = fsm_err | round_state_err_i | pad_state_err_i;
    assign cnt_err_o  = round_cnt_err_i | msg_cnt_err_i;

    // R12
    assert_pass_absorb_R12: assert property (@(posedge clk_i) disable iff (!rst_ni)
        msg_pass_o |-> (state_q == ST_ABSORB));
    // R8
    assert_flush_err_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (state_q == ST_FLUSH && start_i) |-> seq_err_o);
    // R7
    assert_halt_fatal_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (state_q == ST_HALT) |-> fatal_o);

endmodule

// File: tb/sponge_seq_ctrl_tb.sv
module sponge_seq_ctrl_tb;

    localparam logic [3:0] T = 4'b0110;  // strict true
    localparam logic [3:0] F = 4'b1001;  // false
    localparam logic [3:0] L = 4'b0111;  // loosely true only
    localparam logic [3:0] Z = 4'b0000;  // loosely true only
    localparam logic O = 1'b0;
    localparam logic I = 1'b1;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic start = 1'b0, process = 1'b0, run = 1'b0, perm_done = 1'b0, pad_run = 1'b0;
    logic [3:0] done = 4'b1001, absorbed = 4'b1001, escalate = 4'b1001;
    logic pad_serr = 1'b0, round_serr = 1'b0, round_cerr = 1'b0, msg_cerr = 1'b0;
    logic msg_pass, perm_run, seq_err, fatal, cnt_err;

    int checks = 0;
    int errors = 0;
    bit finished = 1'b0;

    always #5 clk = ~clk;

    sponge_seq_ctrl u_dut (
        .clk_i             (clk),
        .rst_ni            (rst_n),
        .start_i           (start),
        .process_i         (process),
        .run_i             (run),
        .done_i            (done),
        .absorbed_i        (absorbed),
        .perm_done_i       (perm_done),
        .escalate_i        (escalate),
        .pad_run_i         (pad_run),
        .pad_state_err_i   (pad_serr),
        .round_state_err_i (round_serr),
        .round_cnt_err_i   (round_cerr),
        .msg_cnt_err_i     (msg_cerr),
        .msg_pass_o        (msg_pass),
        .perm_run_o        (perm_run),
        .seq_err_o         (seq_err),
        .fatal_o           (fatal),
        .cnt_err_o         (cnt_err)
    );

    typedef struct packed {
        logic [3:0] req;
        logic       st;
        logic       pr;
        logic       rn;
        logic [3:0] dn;
        logic [3:0] ab;
        logic       pd;
        logic [3:0] es;
        logic       pad;
        logic       e_pass;
        logic       e_err;
        logic       e_run;
        logic       e_fat;
    } vec_t;

    // Each row is driven after a falling edge and checked before the next rising edge.
    // The e_pass and e_fat columns reflect the state reached by the rows above.
    localparam int NV = 29;
    localparam vec_t VEC [NV] = '{
        '{4'd1,  O,O,O,F,F,O,F,O, O,O,O,O}, // R1 idle, quiet
        '{4'd8,  O,O,I,F,F,O,F,O, O,I,O,O}, // R8 idle run
        '{4'd8,  O,O,O,L,F,O,F,O, O,I,O,O}, // R8 idle loose done
        '{4'd10, O,O,O,F,F,O,F,I, O,O,I,O}, // R10 padder request
        '{4'd2,  I,O,O,F,F,O,F,O, O,O,O,O}, // R2 start
        '{4'd3,  O,O,O,F,L,O,F,O, I,O,O,O}, // R3 loose absorbed keeps absorb
        '{4'd9,  O,I,O,F,F,O,F,O, I,O,O,O}, // R9 first process
        '{4'd9,  O,I,O,F,F,O,F,O, I,I,O,O}, // R9 process while busy
        '{4'd8,  I,O,O,F,F,O,F,O, I,I,O,O}, // R8 absorb start
        '{4'd3,  O,O,O,F,T,O,F,O, I,O,O,O}, // R3 strict absorbed
        '{4'd3,  O,O,O,F,F,O,F,O, O,O,O,O}, // R3 now squeeze
        '{4'd8,  I,O,O,F,F,O,F,O, O,I,O,O}, // R8 squeeze start
        '{4'd4,  O,O,O,L,F,O,F,O, O,O,O,O}, // R4 loose done ignored
        '{4'd4,  O,O,I,T,F,O,F,O, O,O,I,O}, // R4 run wins over done
        '{4'd5,  O,O,O,T,F,O,F,O, O,O,O,O}, // R5 manual run ignores done
        '{4'd8,  I,O,O,F,F,O,F,O, O,I,O,O}, // R8 manual run start
        '{4'd5,  O,O,O,F,F,I,F,O, O,O,O,O}, // R5 permutation complete
        '{4'd4,  O,O,O,T,F,O,F,O, O,O,O,O}, // R4 done to flush
        '{4'd8,  O,O,I,F,F,O,F,O, O,I,O,O}, // R8 flush run
        '{4'd6,  I,O,O,F,F,O,F,O, O,O,O,O}, // R6 back in idle
        '{4'd12, O,O,O,F,F,O,F,O, I,O,O,O}, // R12 pass while absorbing
        '{4'd3,  O,O,O,F,T,O,F,O, I,O,O,O}, // R3
        '{4'd4,  O,O,O,T,F,O,F,O, O,O,O,O}, // R4
        '{4'd6,  O,O,O,F,F,O,F,O, O,O,O,O}, // R6 flush, quiet
        '{4'd6,  I,O,O,F,F,O,F,O, O,O,O,O}, // R6 one-cycle flush
        '{4'd7,  O,O,O,F,F,O,L,O, I,O,O,O}, // R7 loose escalation
        '{4'd7,  O,O,O,F,F,O,F,O, O,O,O,I}, // R7 halted
        '{4'd7,  I,O,O,F,F,O,F,O, O,O,O,I}, // R7 start ignored
        '{4'd7,  O,O,O,F,T,O,F,O, O,O,O,I}  // R7 sticky
    };

    task automatic chk(input logic act, input logic exp, input string req, input string what);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s %s actual=%0b expected=%0b", req, what, act, exp);
        end
    endtask

    task automatic quiet();
        start = O; process = O; run = O; perm_done = O; pad_run = O;
        done = F; absorbed = F; escalate = F;
        pad_serr = O; round_serr = O; round_cerr = O; msg_cerr = O;
    endtask

    initial begin
        string tag;
        quiet();
        rst_n = 1'b0;
        repeat (2) @(negedge clk);
        #1;
        chk(msg_pass, O, "R1", "pass in reset");
        chk(fatal,    O, "R1", "fatal in reset");
        @(negedge clk);
        rst_n = 1'b1;

        for (int i = 0; i < NV; i++) begin
            @(negedge clk);
            start = VEC[i].st; process = VEC[i].pr; run = VEC[i].rn;
            done = VEC[i].dn; absorbed = VEC[i].ab; perm_done = VEC[i].pd;
            escalate = VEC[i].es; pad_run = VEC[i].pad;
            #1;
            tag = $sformatf("R%0d row%0d", VEC[i].req, i);
            chk(msg_pass, VEC[i].e_pass, tag, "msg_pass");
            chk(seq_err,  VEC[i].e_err,  tag, "seq_err");
            chk(perm_run, VEC[i].e_run,  tag, "perm_run");
            chk(fatal,    VEC[i].e_fat,  tag, "fatal");
        end

        // R1: reset leaves halt asynchronously
        @(negedge clk);
        quiet();
        rst_n = 1'b0;
        #1;
        chk(fatal,    O, "R1", "fatal after reset from halt");
        chk(msg_pass, O, "R1", "pass after reset from halt");
        @(negedge clk);
        rst_n = 1'b1;

        // R11: fault aggregation, same cycle
        @(negedge clk);
        round_serr = I; #1;
        chk(fatal, I, "R11", "round state fault");
        round_serr = O; pad_serr = I; #1;
        chk(fatal, I, "R11", "pad state fault");
        pad_serr = O; #1;
        chk(fatal, O, "R11", "no state fault");
        round_cerr = I; #1;
        chk(cnt_err, I, "R11", "round counter fault");
        round_cerr = O; msg_cerr = I; #1;
        chk(cnt_err, I, "R11", "message counter fault");
        msg_cerr = O; #1;
        chk(cnt_err, O, "R11", "no counter fault");

        // R10: software run outside squeeze gives no request
        run = I; #1;
        chk(perm_run, O, "R10", "run in idle");
        chk(seq_err,  I, "R8",  "run in idle");
        run = O;

        // R7: all-zero escalation pattern is loosely true
        @(negedge clk);
        escalate = Z; #1;
        chk(fatal, O, "R7", "before escalation edge");
        @(negedge clk);
        escalate = F; #1;
        chk(fatal, I, "R7", "after escalation edge");
        repeat (3) @(negedge clk);
        start = I; #1;
        chk(seq_err,  O, "R7", "command in halt");
        chk(fatal,    I, "R7", "halt held");
        chk(msg_pass, O, "R7", "pass closed in halt");
        quiet();

        finished = 1'b1;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!finished) begin
            checks++;
            errors++;
            $display("FAIL watchdog actual=timeout expected=finish");
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

endmodule